// File: doc/BRIEF.md
# Bus Hold Arbiter

This block decides which master owns the external address, data and strobe pins: the local bus controller or an outside master that asks for the bus with a hold request. An outside request first passes a two-stage synchronizer. The grant is then given only at a bus cycle boundary. An internal access never touches the pins, so it does not delay the grant. An external cycle that is running must finish before the bus is handed over. The hold latency therefore depends on the kind of cycle in flight.

While the bus is granted away, the block floats the pins and stalls the local controller. If the local controller has an external cycle waiting, the block raises a bus request so the outside master knows it is wanted back. When the outside master withdraws its request, the acknowledge drops. In that same cycle the stall is lifted, so the pending local cycle starts in the next state. All arbitration is active only while the enable bit is set. With the enable bit clear, all outputs stay low and the pins keep their ordinary port use.

All pins are plain level signals. One clock period counts as one state. Every output changes only on a clock edge.

Top module: `bus_hold_arb`

## Requirements
- R1: After reset, hold_ack, bus_req, pins_float and local_stall are all 0.
- R2: While hold_en is 0, hold_req is ignored: hold_ack, pins_float and local_stall stay 0.
- R3: With hold_en set and no external cycle busy, hold_ack rises at the third rising clock edge after hold_req rises, and not earlier.
- R4: While local_busy is 1 with an external cycle kind (cyc_kind 1 = 16-bit, 2 = 8-bit, 3 = treated as external), no grant is given. hold_ack rises at the first edge after local_busy falls, once the request has been synchronized.
- R5: An internal cycle (cyc_kind 0) does not delay the grant, even when local_busy is 1.
- R6: pins_float is 1 in exactly the cycles in which hold_ack is 1.
- R7: local_stall is 1 while a request waits for a boundary and while the bus is granted. It falls in the same cycle as hold_ack.
- R8: While the bus is granted, bus_req follows local_pend with a one-edge delay. bus_req is 0 whenever the bus is not granted.
- R9: When hold_req falls, hold_ack and local_stall fall at the third rising edge after that.
- R10: Clearing hold_en while the bus is granted drops hold_ack, pins_float and local_stall at the next edge.
- R11: A request that is withdrawn while it waits for an external cycle to end never produces a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | State clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_en | input | 1 | Enables the hold, acknowledge and request functions |
| hold_req | input | 1 | Bus request from the outside master, asynchronous |
| local_busy | input | 1 | Local controller has a cycle in progress |
| local_pend | input | 1 | Local controller has an external cycle waiting |
| cyc_kind | input | 2 | Kind of current cycle: 0 internal, 1 external 16-bit, 2 external 8-bit |
| hold_ack | output | 1 | Bus granted to the outside master |
| bus_req | output | 1 | Local controller wants the bus back |
| pins_float | output | 1 | Float enable for the address and strobe drivers |
| local_stall | output | 1 | Holds off new local cycles |

## Verification
Two events can land on the same clock edge: the synchronized request becoming visible, and an external cycle ending. When they coincide, the grant must follow at once and must never come early. The bench keeps an 8-bit external cycle busy past the synchronizer delay, then drops local_busy. It checks that hold_ack is still low before that edge and high right after it. A second case that can coincide is a request withdrawn while a cycle is still busy. That case must leave no grant and no stall once the cycle ends.

// File: rtl/bus_hold_arb_pkg.sv
package bus_hold_arb_pkg;
  typedef enum logic [1:0] {
    ARB_IDLE  = 2'd0,
    ARB_WAIT  = 2'd1,
    ARB_GRANT = 2'd2
  } arb_state_t;

  typedef enum logic [1:0] {
    CYC_INT   = 2'd0,
    CYC_EXT16 = 2'd1,
    CYC_EXT8  = 2'd2,
    CYC_EXTX  = 2'd3
  } cyc_kind_t;
endpackage

// File: rtl/bha_sync.sv
module bha_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic d_out
);
  localparam int LAST = STAGES - 1;
  logic [LAST:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign d_out = chain_q[LAST];
endmodule

// File: rtl/bha_fsm.sv
module bha_fsm
  import bus_hold_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       req_s,
  input  logic       busy,
  input  logic       pend,
  input  logic [1:0] kind,
  output logic       ack,
  output logic       breq,
  output logic       flt,
  output logic       stall
);
  arb_state_t state_q, state_d;
  logic boundary;
  logic ack_q, flt_q, breq_q;

  // an internal access does not use the pins, so it is always a boundary
  assign boundary = !busy || (cyc_kind_t'(kind) == CYC_INT);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ARB_IDLE: begin
        if (en && req_s) state_d = boundary ? ARB_GRANT : ARB_WAIT;
      end
      ARB_WAIT: begin
        if (!en || !req_s) state_d = ARB_IDLE;
        else if (boundary) state_d = ARB_GRANT;
      end
      ARB_GRANT: begin
        if (!en || !req_s) state_d = ARB_IDLE;
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
      ack_q   <= 1'b0;
      flt_q   <= 1'b0;
      breq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      ack_q   <= (state_d == ARB_GRANT);
      flt_q   <= (state_d == ARB_GRANT);
      breq_q  <= (state_d == ARB_GRANT) && pend;
    end
  end

  assign ack   = ack_q;
  assign flt   = flt_q;
  assign breq  = breq_q;
  assign stall = (state_q != ARB_IDLE);
endmodule

// File: rtl/bus_hold_arb.sv
module bus_hold_arb #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hold_en,
  input  logic       hold_req,
  input  logic       local_busy,
  input  logic       local_pend,
  input  logic [1:0] cyc_kind,
  output logic       hold_ack,
  output logic       bus_req,
  output logic       pins_float,
  output logic       local_stall
);
  logic req_sync;

  bha_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (hold_req),
    .d_out (req_sync)
  );

  bha_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (hold_en),
    .req_s (req_sync),
    .busy  (local_busy),
    .pend  (local_pend),
    .kind  (cyc_kind),
    .ack   (hold_ack),
    .breq  (bus_req),
    .flt   (pins_float),
    .stall (local_stall)
  );
endmodule

// File: rtl/bus_hold_arb_chk.sv
module bus_hold_arb_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hold_en,
  input logic       hold_req,
  input logic       local_busy,
  input logic [1:0] cyc_kind,
  input logic       hold_ack,
  input logic       bus_req,
  input logic       pins_float,
  input logic       local_stall
);
  AST_OFF_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_en |=> !hold_ack); // R2

  AST_ACK_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_ack) |-> $past(hold_req, 2)); // R3

  AST_NO_GRANT_MID_EXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_ack && local_busy && cyc_kind != 2'd0) |=> !hold_ack); // R4

  AST_FLOAT_TRACKS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    pins_float == hold_ack); // R6

  AST_STALL_COVERS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack |-> local_stall); // R7

  AST_BREQ_ONLY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> hold_ack); // R8

  AST_OFF_DROPS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_ack && !hold_en) |=> (!hold_ack && !local_stall)); // R10
endmodule

bind bus_hold_arb bus_hold_arb_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .hold_en     (hold_en),
  .hold_req    (hold_req),
  .local_busy  (local_busy),
  .cyc_kind    (cyc_kind),
  .hold_ack    (hold_ack),
  .bus_req     (bus_req),
  .pins_float  (pins_float),
  .local_stall (local_stall)
);

// File: tb/bus_hold_arb_tb.sv
`timescale 1ns/1ps
module bus_hold_arb_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hold_en = 1'b0;
  logic hold_req = 1'b0;
  logic local_busy = 1'b0;
  logic local_pend = 1'b0;
  logic [1:0] cyc_kind = 2'd0;
  logic hold_ack, bus_req, pins_float, local_stall;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  bus_hold_arb u_dut (
    .clk(clk), .rst_n(rst_n), .hold_en(hold_en), .hold_req(hold_req),
    .local_busy(local_busy), .local_pend(local_pend), .cyc_kind(cyc_kind),
    .hold_ack(hold_ack), .bus_req(bus_req), .pins_float(pins_float),
    .local_stall(local_stall)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic go_idle();
    hold_req = 1'b0; local_busy = 1'b0; local_pend = 1'b0;
    cyc_kind = 2'd0; hold_en = 1'b1;
    step(5);
  endtask

  task automatic t_reset();
    chk("R1 ack", hold_ack, 1'b0);
    chk("R1 breq", bus_req, 1'b0);
    chk("R1 float", pins_float, 1'b0);
    chk("R1 stall", local_stall, 1'b0);
  endtask

  task automatic t_disabled();
    hold_en = 1'b0; hold_req = 1'b1;
    step(6);
    chk("R2 ack", hold_ack, 1'b0);
    chk("R2 float", pins_float, 1'b0);
    chk("R2 stall", local_stall, 1'b0);
    go_idle();
  endtask

  task automatic t_grant_latency();
    hold_req = 1'b1;
    step(2);
    chk("R3 early", hold_ack, 1'b0);
    step(1);
    chk("R3 ack", hold_ack, 1'b1);
    chk("R6 float", pins_float, 1'b1);
    chk("R7 stall", local_stall, 1'b1);
    local_pend = 1'b1;
    step(1);
    chk("R8 breq on", bus_req, 1'b1);
    local_pend = 1'b0;
    step(1);
    chk("R8 breq off", bus_req, 1'b0);
    hold_req = 1'b0;
    step(2);
    chk("R9 still held", hold_ack, 1'b1);
    step(1);
    chk("R9 ack off", hold_ack, 1'b0);
    chk("R9 stall off", local_stall, 1'b0);
    chk("R6 float off", pins_float, 1'b0);
    go_idle();
  endtask

  task automatic t_ext_wait();
    local_busy = 1'b1; cyc_kind = 2'd2; hold_req = 1'b1;
    step(6);
    chk("R4 no grant", hold_ack, 1'b0);
    chk("R7 wait stall", local_stall, 1'b1);
    local_pend = 1'b1;
    step(1);
    chk("R8 no breq unheld", bus_req, 1'b0);
    local_busy = 1'b0;
    step(1);
    chk("R4 grant at end", hold_ack, 1'b1);
    chk("R8 breq", bus_req, 1'b1);
    go_idle();
  endtask

  task automatic t_internal();
    local_busy = 1'b1; cyc_kind = 2'd0; hold_req = 1'b1;
    step(3);
    chk("R5 internal grant", hold_ack, 1'b1);
    go_idle();
  endtask

  task automatic t_disable_held();
    hold_req = 1'b1;
    step(4);
    chk("R10 held", hold_ack, 1'b1);
    hold_en = 1'b0;
    step(1);
    chk("R10 ack", hold_ack, 1'b0);
    chk("R10 float", pins_float, 1'b0);
    chk("R10 stall", local_stall, 1'b0);
    go_idle();
  endtask

  task automatic t_withdraw();
    local_busy = 1'b1; cyc_kind = 2'd1; hold_req = 1'b1;
    step(4);
    hold_req = 1'b0;
    step(3);
    local_busy = 1'b0;
    step(2);
    chk("R11 ack", hold_ack, 1'b0);
    chk("R11 stall", local_stall, 1'b0);
    go_idle();
  endtask

  initial begin
    step(3);
    t_reset();
    rst_n = 1'b1;
    step(2);
    t_reset();
    t_disabled();
    t_grant_latency();
    t_ext_wait();
    t_internal();
    t_disable_held();
    t_withdraw();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule